// File: doc/BRIEF.md
# Received Frame Address Filter

This block sits behind a wireless receiver and decides, frame by frame, whether a received MAC frame should go on to the host. The receiver feeds it the frame one byte per valid cycle, with a start pulse on the first byte. The first five bytes are the PHY prefix and are skipped. After them come two bytes of frame control, two bytes of duration, and then address 1, address 2 and address 3.

The filter compares address 1 with a programmed station address and address 3 with a programmed BSSID. It also classifies the frame from its type and subtype. A 14-bit admit mask holds one enable bit per frame class. A frame passes when at least one class it belongs to is enabled. The verdict is a one-cycle pass pulse or a one-cycle drop pulse.

The header words it captures (frame control with duration, address 1 and address 2) can be read back through a small register port. The same port programs the mask and the two addresses.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every register reads zero, no pass or drop pulse appears, and a frame is dropped because the mask is all zero.
- R2: Byte indices count from 0 at the frame-start byte. Indices 0 to 4 are skipped. Index 5 is frame control byte 0, index 6 is frame control byte 1, indices 7 and 8 are the duration bytes, 9 to 14 are address 1, 15 to 20 are address 2 and 21 to 26 are address 3. Each address byte k is held in bits 8k+7:8k.
- R3: The register map, selected by regAddr:
  - 0 is the mask; bits above 13 read zero.
  - 1 and 2 are the station address, low 32 bits and high 16 bits.
  - 3 and 4 are the BSSID, low and high.
  - 5 is the captured word {dur1, dur0, fc1, fc0}.
  - 6 and 7 are address 1, low and high.
  - 8 and 9 are address 2, low and high.
  - High registers read zero above bit 15. Writes to registers 5 to 9 are ignored.
- R4: Each verdict is one cycle long, and exactly one of rxPass and rxDrop is high.
  - For a control frame (fc0 bits 3:2 equal to 01), the verdict appears in the cycle after byte 14 is taken.
  - For any other frame, it appears in the cycle after byte 26 is taken.
- R5: Three mask bits admit frames by address 1 alone. Bit 9 admits address 1 equal to the station address. Bit 10 admits address 1 of all ones. Bit 11 admits address 1 of all zeros.
- R6: Mask bit 1 admits group frames, that is, address 1 beginning 01:00:5E or 33:33. Any other prefix is not admitted by this bit.
- R7: Three mask bits cover management frames (type 00) and BSS membership:
  - Bit 4 admits beacons (subtype 1000) and probe responses (subtype 0101) from any BSS.
  - Bit 12 admits beacons only, and only when address 3 equals the BSSID.
  - Bit 6 admits non-control frames whose address 3 differs from the BSSID.
- R8: Mask bit 5 admits every control frame. Bit 7 admits PS-Poll, which is control subtype 1010. Bit 8 admits probe requests, which are management subtype 0100.
- R9: Mask bit 13 admits every frame. Bits 0, 2 and 3 are stored but admit nothing.
- R10: A start pulse aborts any partial parse and restarts the byte index. A frame cut short before its decision byte gives no verdict.
- R11: A frame passes when any enabled class matches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Marks the first byte of a frame |
| byteValid | input | 1 | byteData carries a frame byte |
| byteData | input | 8 | Received byte |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register select for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| rxPass | output | 1 | One-cycle pulse: frame admitted |
| rxDrop | output | 1 | One-cycle pulse: frame rejected |

## Verification
Each mask bit is enabled on its own and tried against two frames: one that belongs to its class and one that only just misses it. The near misses are a group prefix of 01:00:5F, a probe response where a beacon is required, a PS-Poll bench against an ACK, and address 3 one BSSID away. These show that each class decodes the exact type, subtype or address field it should. Control frames and management or data frames are each timed against the byte count, which separates the early decision from the late one. Further runs cover frames cut off mid-header, the dead mask bits, and masks with several bits set, to show that parse abort, the ignored bits and the OR of classes all behave as required.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;

  localparam int ADMIT_W    = 14;
  localparam int REG_W      = 32;
  localparam int ADDR_BYTES = 6;
  localparam int HDR_OFF_W  = 5;

  // header offsets counted after the PHY prefix
  localparam int OFF_FCDUR  = 0;
  localparam int OFF_A1     = 4;
  localparam int OFF_A2     = OFF_A1 + ADDR_BYTES;
  localparam int OFF_A3     = OFF_A2 + ADDR_BYTES;
  localparam int HDR_LEN    = OFF_A3 + ADDR_BYTES;
  localparam int OFF_A1_END = OFF_A2 - 1;
  localparam int OFF_A3_END = HDR_LEN - 1;

  // admit mask bit positions
  localparam int BIT_GROUP    = 1;
  localparam int BIT_BCN_ANY  = 4;
  localparam int BIT_CONTROL  = 5;
  localparam int BIT_OTHERBSS = 6;
  localparam int BIT_PSPOLL   = 7;
  localparam int BIT_PRBREQ   = 8;
  localparam int BIT_OWN      = 9;
  localparam int BIT_ONES     = 10;
  localparam int BIT_ZEROS    = 11;
  localparam int BIT_BCN_OWN  = 12;
  localparam int BIT_ALL      = 13;

  typedef enum logic [3:0] {
    SEL_MASK   = 4'd0,
    SEL_OWN_LO = 4'd1,
    SEL_OWN_HI = 4'd2,
    SEL_BSS_LO = 4'd3,
    SEL_BSS_HI = 4'd4,
    SEL_FCDUR  = 4'd5,
    SEL_A1_LO  = 4'd6,
    SEL_A1_HI  = 4'd7,
    SEL_A2_LO  = 4'd8,
    SEL_A2_HI  = 4'd9
  } regSel_e;

  typedef struct packed {
    logic                 hdrWr;
    logic [HDR_OFF_W-1:0] hdrOff;
    logic                 evalNow;
  } ctlStrobes_t;

endpackage

// File: rtl/rx_addr_filter_ctrl.sv
module rx_addr_filter_ctrl
  import rx_addr_filter_pkg::*;
#(
  parameter int PREFIX_LEN = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        byteValid,
  input  logic        isControl,
  output ctlStrobes_t strobes
);

  localparam int TOTAL = PREFIX_LEN + HDR_LEN;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] byteIdx;
  logic [CNT_W-1:0] curIdx;
  logic [CNT_W-1:0] offIdx;
  logic             active;
  logic             take;
  logic             inHdr;
  logic             evalHit;
  logic             evalReg;

  assign curIdx = frameStart ? '0 : byteIdx;
  assign take   = byteValid && (frameStart || active);
  assign inHdr  = take && (curIdx >= CNT_W'(PREFIX_LEN)) && (curIdx < CNT_W'(TOTAL));
  assign offIdx = curIdx - CNT_W'(PREFIX_LEN);

  // control frames end their addressing after address 1
  assign evalHit = inHdr &&
                   (( isControl && offIdx == CNT_W'(OFF_A1_END)) ||
                    (!isControl && offIdx == CNT_W'(OFF_A3_END)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
      active  <= 1'b0;
      evalReg <= 1'b0;
    end else begin
      evalReg <= evalHit;
      if (frameStart) begin
        active  <= 1'b1;
        byteIdx <= byteValid ? CNT_W'(1) : '0;
      end else if (take) begin
        byteIdx <= byteIdx + CNT_W'(1);
        if (byteIdx == CNT_W'(TOTAL - 1)) active <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.hdrWr   = inHdr;
    strobes.hdrOff  = HDR_OFF_W'(offIdx);
    strobes.evalNow = evalReg;
  end

endmodule

// File: rtl/rx_addr_filter_dp.sv
module rx_addr_filter_dp
  import rx_addr_filter_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [7:0]        byteData,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              isControl,
  output logic              rxPass,
  output logic              rxDrop
);

  localparam int AW = 8 * ADDR_BYTES;

  logic [ADMIT_W-1:0] admitMask;
  logic [AW-1:0]      ownAddr;
  logic [AW-1:0]      bssAddr;
  logic [REG_W-1:0]   capFcDur;
  logic [AW-1:0]      capA1;
  logic [AW-1:0]      capA2;
  logic [AW-1:0]      capA3;

  logic               selOk;
  regSel_e            sel;

  if (REG_AW > 4) begin : gWideAddr
    assign selOk = (regAddr[REG_AW-1:4] == '0);
  end else begin : gNarrowAddr
    assign selOk = 1'b1;
  end
  assign sel = regSel_e'(regAddr[3:0]);

  // programmable registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      admitMask <= '0;
      ownAddr   <= '0;
      bssAddr   <= '0;
    end else if (regWrEn && selOk) begin
      case (sel)
        SEL_MASK:   admitMask      <= regWrData[ADMIT_W-1:0];
        SEL_OWN_LO: ownAddr[31:0]  <= regWrData;
        SEL_OWN_HI: ownAddr[AW-1:32] <= regWrData[AW-33:0];
        SEL_BSS_LO: bssAddr[31:0]  <= regWrData;
        SEL_BSS_HI: bssAddr[AW-1:32] <= regWrData[AW-33:0];
        default: ;
      endcase
    end
  end

  // header capture, one byte lane per header offset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capFcDur <= '0;
      capA1    <= '0;
      capA2    <= '0;
      capA3    <= '0;
    end else if (strobes.hdrWr) begin
      for (int k = 0; k < 4; k++)
        if (strobes.hdrOff == HDR_OFF_W'(OFF_FCDUR + k)) capFcDur[8*k +: 8] <= byteData;
      for (int k = 0; k < ADDR_BYTES; k++) begin
        if (strobes.hdrOff == HDR_OFF_W'(OFF_A1 + k)) capA1[8*k +: 8] <= byteData;
        if (strobes.hdrOff == HDR_OFF_W'(OFF_A2 + k)) capA2[8*k +: 8] <= byteData;
        if (strobes.hdrOff == HDR_OFF_W'(OFF_A3 + k)) capA3[8*k +: 8] <= byteData;
      end
    end
  end

  // frame classification
  logic [1:0]         fType;
  logic [3:0]         fSub;
  logic               isMgmt;
  logic               isBeacon;
  logic               a1Group;
  logic               bssMatch;
  logic [ADMIT_W-1:0] classHit;
  logic               admit;

  assign fType     = capFcDur[3:2];
  assign fSub      = capFcDur[7:4];
  assign isMgmt    = (fType == 2'b00);
  assign isControl = (fType == 2'b01);
  assign isBeacon  = isMgmt && (fSub == 4'b1000);
  assign bssMatch  = (capA3 == bssAddr);
  assign a1Group   = (capA1[7:0] == 8'h01 && capA1[15:8] == 8'h00 && capA1[23:16] == 8'h5E) ||
                     (capA1[7:0] == 8'h33 && capA1[15:8] == 8'h33);

  always_comb begin
    classHit               = '0;
    classHit[BIT_GROUP]    = a1Group;
    classHit[BIT_BCN_ANY]  = isBeacon || (isMgmt && fSub == 4'b0101);
    classHit[BIT_CONTROL]  = isControl;
    classHit[BIT_OTHERBSS] = !isControl && !bssMatch;
    classHit[BIT_PSPOLL]   = isControl && (fSub == 4'b1010);
    classHit[BIT_PRBREQ]   = isMgmt && (fSub == 4'b0100);
    classHit[BIT_OWN]      = (capA1 == ownAddr);
    classHit[BIT_ONES]     = &capA1;
    classHit[BIT_ZEROS]    = ~|capA1;
    classHit[BIT_BCN_OWN]  = isBeacon && bssMatch;
    classHit[BIT_ALL]      = 1'b1;
  end

  assign admit  = |(classHit & admitMask);
  assign rxPass = strobes.evalNow && admit;
  assign rxDrop = strobes.evalNow && !admit;

  // read mux
  always_comb begin
    regRdData = '0;
    if (selOk) begin
      case (sel)
        SEL_MASK:   regRdData[ADMIT_W-1:0] = admitMask;
        SEL_OWN_LO: regRdData = ownAddr[31:0];
        SEL_OWN_HI: regRdData[AW-33:0] = ownAddr[AW-1:32];
        SEL_BSS_LO: regRdData = bssAddr[31:0];
        SEL_BSS_HI: regRdData[AW-33:0] = bssAddr[AW-1:32];
        SEL_FCDUR:  regRdData = capFcDur;
        SEL_A1_LO:  regRdData = capA1[31:0];
        SEL_A1_HI:  regRdData[AW-33:0] = capA1[AW-1:32];
        SEL_A2_LO:  regRdData = capA2[31:0];
        SEL_A2_HI:  regRdData[AW-33:0] = capA2[AW-1:32];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int PREFIX_LEN = 5,
  parameter int REG_AW     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              rxPass,
  output logic              rxDrop
);

  ctlStrobes_t strobes;
  logic        isControl;

  rx_addr_filter_ctrl #(.PREFIX_LEN(PREFIX_LEN)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .byteValid  (byteValid),
    .isControl  (isControl),
    .strobes    (strobes)
  );

  rx_addr_filter_dp #(.REG_AW(REG_AW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .byteData   (byteData),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .isControl  (isControl),
    .rxPass     (rxPass),
    .rxDrop     (rxDrop)
  );

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int PREFIX_LEN = 5,
  parameter int REG_AW     = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              byteValid,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [31:0]       regRdData,
  input logic              rxPass,
  input logic              rxDrop
);

  localparam int MIN_BYTES = PREFIX_LEN + 10;

  // independent count of bytes since the latest start pulse, saturating
  logic [7:0] seenBytes;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenBytes <= '0;
    else if (frameStart) seenBytes <= byteValid ? 8'd1 : 8'd0;
    else if (byteValid && seenBytes != 8'hFF) seenBytes <= seenBytes + 8'd1;
  end

  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rxPass && rxDrop)); // R4

  AST_VERDICT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (rxPass || rxDrop) |=> !(rxPass || rxDrop)); // R4

  AST_VERDICT_AFTER_ADDR1: assert property (@(posedge clk) disable iff (!rstN)
    (rxPass || rxDrop) |-> (seenBytes >= 8'(MIN_BYTES))); // R10

  AST_MASK_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REG_AW'(0)) |=>
      (regAddr != REG_AW'(0) || regRdData == {18'b0, $past(regWrData[13:0])})); // R3

endmodule

bind rx_addr_filter rx_addr_filter_chk #(.PREFIX_LEN(PREFIX_LEN), .REG_AW(REG_AW)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .byteValid  (byteValid),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .rxPass     (rxPass),
  .rxDrop     (rxDrop)
);

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;

  localparam logic [47:0] OWN   = 48'h665544332211;
  localparam logic [47:0] BSS   = 48'h5A4B3C2D1E0F;
  localparam logic [47:0] OTHER = 48'h9988776655AA;
  localparam logic [47:0] BCAST = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] ZERO  = 48'h000000000000;
  localparam logic [7:0] FC_DATA = 8'h08, FC_BCN = 8'h80, FC_PRSP = 8'h50,
                         FC_PREQ = 8'h40, FC_PSPOLL = 8'hA4, FC_ACK = 8'hD4;
  localparam int LATE = 27;
  localparam int EARLY = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = 4'd0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        rxPass, rxDrop;

  int checks = 0;
  int fails = 0;
  int passCnt = 0;
  int dropCnt = 0;
  int pulseAt = -1;
  int benchIdx = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_addr_filter uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
    .byteData(byteData), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rxPass(rxPass), .rxDrop(rxDrop)
  );

  always @(posedge clk) begin
    if (frameStart) benchIdx <= byteValid ? 1 : 0;
    else if (byteValid) benchIdx <= benchIdx + 1;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (rxPass) begin passCnt++; pulseAt = benchIdx; end
      if (rxDrop) begin dropCnt++; pulseAt = benchIdx; end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] frameByte(input int i, input logic [7:0] fc0,
      input logic [47:0] a1, input logic [47:0] a2, input logic [47:0] a3);
    int o;
    if (i < 5) return 8'hC0 + 8'(i);
    o = i - 5;
    if (o == 0) return fc0;
    if (o == 1) return 8'h00;
    if (o == 2) return 8'h3A;
    if (o == 3) return 8'h01;
    if (o < 10) return a1[8*(o-4) +: 8];
    if (o < 16) return a2[8*(o-10) +: 8];
    if (o < 22) return a3[8*(o-16) +: 8];
    return 8'h55;
  endfunction

  task automatic sendFrame(input logic [7:0] fc0, input logic [47:0] a1,
      input logic [47:0] a2, input logic [47:0] a3, input int nBytes);
    for (int i = 0; i < nBytes; i++) begin
      @(negedge clk);
      frameStart = (i == 0);
      byteValid = 1'b1;
      byteData = frameByte(i, fc0, a1, a2, a3);
    end
    @(negedge clk);
    frameStart = 1'b0;
    byteValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic expectFrame(input string req, input logic [7:0] fc0, input logic [47:0] a1,
      input logic [47:0] a3, input bit expPass, input int expAt);
    passCnt = 0; dropCnt = 0; pulseAt = -1;
    sendFrame(fc0, a1, OTHER, a3, 29);
    check(passCnt == (expPass ? 1 : 0) && dropCnt == (expPass ? 0 : 1), req,
          passCnt * 16 + dropCnt, expPass ? 16 : 1);
    check(pulseAt == expAt, {req, " timing R4"}, pulseAt, expAt);
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int a = 0; a < 10; a++) begin
      readReg(4'(a), v);
      check(v == 32'h0, "R1 reset register", v, 0);
    end
    check(passCnt == 0 && dropCnt == 0, "R1 no verdict at reset", passCnt + dropCnt, 0);
    expectFrame("R1 zero mask drops", FC_DATA, BCAST, BSS, 1'b0, LATE);
  endtask

  task automatic testRegs();
    logic [31:0] v;
    writeReg(4'd0, 32'hFFFFFFFF);
    readReg(4'd0, v); check(v == 32'h3FFF, "R3 mask width", v, 32'h3FFF);
    writeReg(4'd0, 32'h0);
    writeReg(4'd1, OWN[31:0]);
    writeReg(4'd2, {16'hABCD, OWN[47:32]});
    writeReg(4'd3, BSS[31:0]);
    writeReg(4'd4, {16'h1234, BSS[47:32]});
    readReg(4'd1, v); check(v == OWN[31:0], "R3 own low", v, OWN[31:0]);
    readReg(4'd2, v); check(v == {16'h0, OWN[47:32]}, "R3 own high", v, OWN[47:32]);
    readReg(4'd3, v); check(v == BSS[31:0], "R3 bssid low", v, BSS[31:0]);
    readReg(4'd4, v); check(v == {16'h0, BSS[47:32]}, "R3 bssid high", v, BSS[47:32]);
    writeReg(4'd6, 32'h12345678);
    readReg(4'd6, v); check(v == 32'hFFFFFFFF, "R3 capture write ignored", v, 32'hFFFFFFFF);
  endtask

  task automatic testCapture();
    logic [31:0] v;
    sendFrame(FC_DATA, OWN, OTHER, BSS, 29);
    readReg(4'd5, v); check(v == 32'h013A0008, "R2 fc/dur word", v, 32'h013A0008);
    readReg(4'd6, v); check(v == OWN[31:0], "R2 addr1 low", v, OWN[31:0]);
    readReg(4'd7, v); check(v == {16'h0, OWN[47:32]}, "R2 addr1 high", v, OWN[47:32]);
    readReg(4'd8, v); check(v == OTHER[31:0], "R2 addr2 low", v, OTHER[31:0]);
    readReg(4'd9, v); check(v == {16'h0, OTHER[47:32]}, "R2 addr2 high", v, OTHER[47:32]);
  endtask

  task automatic testAddr1Classes();
    writeReg(4'd0, 32'h1 << 9);
    expectFrame("R5 own unicast", FC_DATA, OWN, BSS, 1'b1, LATE);
    expectFrame("R5 foreign unicast", FC_DATA, OTHER, BSS, 1'b0, LATE);
    writeReg(4'd0, 32'h1 << 10);
    expectFrame("R5 all ones", FC_DATA, BCAST, BSS, 1'b1, LATE);
    writeReg(4'd0, 32'h1 << 11);
    expectFrame("R5 all zeros", FC_DATA, ZERO, BSS, 1'b1, LATE);
    expectFrame("R5 zeros bit vs own", FC_DATA, OWN, BSS, 1'b0, LATE);
  endtask

  task automatic testGroup();
    writeReg(4'd0, 32'h1 << 1);
    expectFrame("R6 group 01:00:5E", FC_DATA, 48'h3322115E0001, BSS, 1'b1, LATE);
    expectFrame("R6 group 33:33", FC_DATA, 48'h443322113333, BSS, 1'b1, LATE);
    expectFrame("R6 near miss 01:00:5F", FC_DATA, 48'h3322115F0001, BSS, 1'b0, LATE);
  endtask

  task automatic testBeacons();
    writeReg(4'd0, 32'h1 << 4);
    expectFrame("R7 beacon any bss", FC_BCN, BCAST, OTHER, 1'b1, LATE);
    expectFrame("R7 probe response", FC_PRSP, OTHER, OTHER, 1'b1, LATE);
    expectFrame("R7 data not beacon", FC_DATA, OTHER, OTHER, 1'b0, LATE);
    writeReg(4'd0, 32'h1 << 12);
    expectFrame("R7 own beacon", FC_BCN, BCAST, BSS, 1'b1, LATE);
    expectFrame("R7 foreign beacon", FC_BCN, BCAST, OTHER, 1'b0, LATE);
    expectFrame("R7 own probe response", FC_PRSP, BCAST, BSS, 1'b0, LATE);
    writeReg(4'd0, 32'h1 << 6);
    expectFrame("R7 other bss data", FC_DATA, OTHER, OTHER, 1'b1, LATE);
    expectFrame("R7 same bss data", FC_DATA, OTHER, BSS, 1'b0, LATE);
    expectFrame("R7 control not other bss", FC_ACK, OTHER, OTHER, 1'b0, EARLY);
  endtask

  task automatic testControl();
    writeReg(4'd0, 32'h1 << 5);
    expectFrame("R8 control ack", FC_ACK, OTHER, OTHER, 1'b1, EARLY);
    expectFrame("R8 data not control", FC_DATA, OTHER, OTHER, 1'b0, LATE);
    writeReg(4'd0, 32'h1 << 7);
    expectFrame("R8 ps-poll", FC_PSPOLL, OTHER, OTHER, 1'b1, EARLY);
    expectFrame("R8 ack not ps-poll", FC_ACK, OTHER, OTHER, 1'b0, EARLY);
    writeReg(4'd0, 32'h1 << 8);
    expectFrame("R8 probe request", FC_PREQ, BCAST, OTHER, 1'b1, LATE);
    expectFrame("R8 beacon not probe req", FC_BCN, BCAST, OTHER, 1'b0, LATE);
  endtask

  task automatic testMonitorAndDead();
    writeReg(4'd0, 32'h1 << 13);
    expectFrame("R9 monitor all", FC_DATA, OTHER, OTHER, 1'b1, LATE);
    writeReg(4'd0, 32'h0000000D);
    expectFrame("R9 dead bits", FC_BCN, BCAST, BSS, 1'b0, LATE);
  endtask

  task automatic testAbort();
    logic [31:0] v;
    writeReg(4'd0, 32'h1 << 10);
    passCnt = 0; dropCnt = 0;
    sendFrame(FC_BCN, BCAST, OTHER, OTHER, 20);
    sendFrame(FC_ACK, BCAST, OTHER, OTHER, 12);
    check(passCnt + dropCnt == 0, "R10 cut frames give no verdict", passCnt + dropCnt, 0);
    sendFrame(FC_DATA, BCAST, OWN, BSS, 20);
    expectFrame("R10 restart after abort", FC_DATA, BCAST, BSS, 1'b1, LATE);
    readReg(4'd8, v); check(v == OTHER[31:0], "R10 capture from new frame", v, OTHER[31:0]);
  endtask

  task automatic testOr();
    writeReg(4'd0, (32'h1 << 9) | (32'h1 << 10));
    expectFrame("R11 or bcast", FC_DATA, BCAST, BSS, 1'b1, LATE);
    expectFrame("R11 or own", FC_DATA, OWN, BSS, 1'b1, LATE);
    expectFrame("R11 or neither", FC_DATA, OTHER, BSS, 1'b0, LATE);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testCapture();
    testAddr1Classes();
    testGroup();
    testBeacons();
    testControl();
    testMonitorAndDead();
    testAbort();
    testOr();
    finishRun();
  end

endmodule